// File: doc/BRIEF.md
# Fixed Twiddle Complex Multiplier

This block rotates a streaming complex sample by one of four fixed factors used just before the final butterfly of a 128-point pipelined transform: unity, -j, W^16 and W^48 (with W = exp(-j2π/128)). It contains no general multiplier. The two diagonal factors share one pair of shift-and-add networks built from a canonic-signed-digit encoding of cos(π/4). The unity and -j factors are pure wiring: pass, swap and negate.

Each cycle the caller presents a 13-bit two's complement real and imaginary sample, a valid strobe, and a 2-bit factor code taken from the stage counter. The rotated sample leaves two clock cycles later with its valid strobe, whatever the code. It is rounded to nearest and clamped to the 13-bit range. Between valid results the outputs keep the last result.

Top module: `twiddle_csd_mult`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two rising clock edges, for every factor code.
- R2: Code 2'b00 (unity) gives out_re = in_re and out_im = in_im.
- R3: Code 2'b10 (-j) gives out_re = in_im and out_im = -in_re. When in_re = -4096, out_im saturates to 4095.
- R4: Code 2'b01 (W^16) gives out_re = Q(a+b) and out_im = Q(b-a), with a = in_re and b = in_im. Q(x) = x·181/256, where 181/256 is the CSD constant 1 - 2^-2 - 2^-4 + 2^-6 + 2^-8.
- R5: Code 2'b11 (W^48) gives out_re = Q(b-a) and out_im = Q(-(a+b)). The negation is applied before rounding.
- R6: Rounding is to nearest with ties toward +infinity, i.e. floor(x + 1/2). For example, a = b = 64 under W^16 gives out_re = 91, and under W^48 gives out_im = -90.
- R7: Every result outside [-4096, 4095] is clamped to the nearer limit. For example, a = b = 4095 under W^16 gives out_re = 4095, and a = b = -4096 gives out_re = -4096.
- R8: While `rst_n` is low, `out_valid`, `out_re` and `out_im` are 0.
- R9: In a cycle where `out_valid` is 0, `out_re` and `out_im` hold the value of the most recent valid result, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sel | input | 2 | Factor code: 00 unity, 01 W^16, 10 -j, 11 W^48 |
| in_re | input | 13 | Real part of input, two's complement |
| in_im | input | 13 | Imaginary part of input, two's complement |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_re | output | 13 | Real part of rotated sample |
| out_im | output | 13 | Imaginary part of rotated sample |

## Verification
The hardest conditions to reach are the exact rounding tie and the saturation of the diagonal products. A tie needs a + b to be an odd multiple of 128. Saturation needs |a + b| above about 5790, which uniform random inputs hit only now and then. Directed vectors therefore place a = b = 64 under both diagonal codes, the four extreme corners, and -4096 through the -j path. A fixed-seed random stream then mixes all codes, with gaps in the valid strobe that exercise the hold behaviour.

// File: rtl/twcm_pkg.sv
package twcm_pkg;
   typedef enum logic [1:0] {
      TW_ONE  = 2'b00,
      TW_W16  = 2'b01,
      TW_NEGJ = 2'b10,
      TW_W48  = 2'b11
   } tw_sel_e;
endpackage

// File: rtl/twcm_csd_const.sv
// Constant multiplier built from signed shift-and-add terms.
// Bit i of POS_MASK adds x*2^i and bit i of NEG_MASK subtracts x*2^i.
// The result is scaled by 2^FRAC relative to the real constant.
module twcm_csd_const #(
   parameter int unsigned IW       = 14,
   parameter int unsigned FRAC     = 8,
   parameter int unsigned RW       = IW + FRAC + 1,
   parameter logic [FRAC:0] POS_MASK = 9'b100000101,
   parameter logic [FRAC:0] NEG_MASK = 9'b001010000
) (
   input  logic signed [IW-1:0] x,
   output logic signed [RW-1:0] prod
);
   localparam logic [FRAC:0] NZ_MASK = POS_MASK | NEG_MASK;

   if ((POS_MASK & NEG_MASK) != '0) begin : g_bad_overlap
      $error("twcm_csd_const: a digit is both positive and negative");
   end
   if ((NZ_MASK & (NZ_MASK >> 1)) != '0) begin : g_bad_csd
      $error("twcm_csd_const: adjacent nonzero digits, not canonic");
   end
   if (RW < IW + FRAC + 1) begin : g_bad_rw
      $error("twcm_csd_const: result width too small");
   end

   logic signed [RW-1:0] x_ext;
   logic signed [RW-1:0] term [FRAC+1];

   assign x_ext = {{(RW-IW){x[IW-1]}}, x};

   for (genvar i = 0; i <= FRAC; i++) begin : g_digit
      if (POS_MASK[i]) begin : g_pos
         assign term[i] = x_ext <<< i;
      end else if (NEG_MASK[i]) begin : g_neg
         assign term[i] = -(x_ext <<< i);
      end else begin : g_zero
         assign term[i] = '0;
      end
   end

   always_comb begin
      prod = '0;
      for (int k = 0; k <= FRAC; k++) begin
         prod = prod + term[k];
      end
   end
endmodule

// File: rtl/twcm_round_sat.sv
// Drops FRAC fraction bits (to nearest, or truncating) and clamps to OW bits.
module twcm_round_sat #(
   parameter int unsigned RW            = 23,
   parameter int unsigned FRAC          = 8,
   parameter int unsigned OW            = 13,
   parameter bit          ROUND_NEAREST = 1'b1
) (
   input  logic signed [RW-1:0] raw,
   output logic signed [OW-1:0] y
);
   if (FRAC < 1) begin : g_bad_frac
      $error("twcm_round_sat: FRAC must be at least 1");
   end
   if (RW < OW + FRAC) begin : g_bad_width
      $error("twcm_round_sat: raw width smaller than output plus fraction");
   end

   localparam logic signed [RW:0] HALF =
      {{(RW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
   localparam logic signed [RW:0] MAXV =
      {{(RW-OW+2){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [RW:0] MINV =
      {{(RW-OW+2){1'b1}}, {(OW-1){1'b0}}};

   logic signed [RW:0] raw_ext;
   logic signed [RW:0] biased;
   logic signed [RW:0] q;

   assign raw_ext = {raw[RW-1], raw};

   if (ROUND_NEAREST) begin : g_nearest
      assign biased = raw_ext + HALF;
   end else begin : g_trunc
      assign biased = raw_ext;
   end

   assign q = biased >>> FRAC;

   always_comb begin
      if (q > MAXV) begin
         y = MAXV[OW-1:0];
      end else if (q < MINV) begin
         y = MINV[OW-1:0];
      end else begin
         y = q[OW-1:0];
      end
   end
endmodule

// File: rtl/twiddle_csd_mult.sv
module twiddle_csd_mult
   import twcm_pkg::*;
#(
   parameter int unsigned W             = 13,
   parameter int unsigned FRAC          = 8,
   parameter logic [FRAC:0] C_POS       = 9'b100000101,
   parameter logic [FRAC:0] C_NEG       = 9'b001010000,
   parameter bit          ROUND_NEAREST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [1:0]          in_sel,
   input  logic signed [W-1:0] in_re,
   input  logic signed [W-1:0] in_im,
   output logic                out_valid,
   output logic signed [W-1:0] out_re,
   output logic signed [W-1:0] out_im
);
   localparam int unsigned SW = W + 1;
   localparam int unsigned RW = SW + FRAC + 1;

   if (W < 4) begin : g_bad_w
      $error("twiddle_csd_mult: W must be at least 4");
   end

   // ---------------- stage 1: pre-adders and operand capture ----------------
   logic                s1_valid;
   tw_sel_e             s1_sel;
   logic signed [W-1:0] s1_re, s1_im;
   logic signed [SW-1:0] s1_sum, s1_dif;
   logic signed [SW-1:0] re_x, im_x;

   assign re_x = {in_re[W-1], in_re};
   assign im_x = {in_im[W-1], in_im};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sel   <= TW_ONE;
         s1_re    <= '0;
         s1_im    <= '0;
         s1_sum   <= '0;
         s1_dif   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sel <= tw_sel_e'(in_sel);
            s1_re  <= in_re;
            s1_im  <= in_im;
            s1_sum <= re_x + im_x;
            s1_dif <= im_x - re_x;
         end
      end
   end

   // ---------------- stage 2: constant products, routing, rounding ----------
   logic signed [RW-1:0] p_sum, p_dif;

   twcm_csd_const #(.IW(SW), .FRAC(FRAC), .RW(RW),
                    .POS_MASK(C_POS), .NEG_MASK(C_NEG)) u_mul_sum (
      .x(s1_sum), .prod(p_sum));

   twcm_csd_const #(.IW(SW), .FRAC(FRAC), .RW(RW),
                    .POS_MASK(C_POS), .NEG_MASK(C_NEG)) u_mul_dif (
      .x(s1_dif), .prod(p_dif));

   logic signed [RW-1:0] re_scaled, im_scaled;
   logic signed [RW-1:0] raw_re, raw_im;

   assign re_scaled = {{(RW-W){s1_re[W-1]}}, s1_re} <<< FRAC;
   assign im_scaled = {{(RW-W){s1_im[W-1]}}, s1_im} <<< FRAC;

   always_comb begin
      unique case (s1_sel)
         TW_ONE: begin
            raw_re = re_scaled;
            raw_im = im_scaled;
         end
         TW_W16: begin
            raw_re = p_sum;
            raw_im = p_dif;
         end
         TW_NEGJ: begin
            raw_re = im_scaled;
            raw_im = -re_scaled;
         end
         default: begin
            raw_re = p_dif;
            raw_im = -p_sum;
         end
      endcase
   end

   logic signed [W-1:0] nxt_re, nxt_im;

   twcm_round_sat #(.RW(RW), .FRAC(FRAC), .OW(W),
                    .ROUND_NEAREST(ROUND_NEAREST)) u_rs_re (
      .raw(raw_re), .y(nxt_re));

   twcm_round_sat #(.RW(RW), .FRAC(FRAC), .OW(W),
                    .ROUND_NEAREST(ROUND_NEAREST)) u_rs_im (
      .raw(raw_im), .y(nxt_im));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_re <= nxt_re;
            out_im <= nxt_im;
         end
      end
   end

   // ---------------- assertions ----------------
   localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   AST_VALID_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid); // R1
   AST_VALID_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid); // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid); // R1
   AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_sel == TW_ONE) |=>
         (out_re == $past(s1_re) && out_im == $past(s1_im))); // R2
   AST_NEGJ_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_sel == TW_NEGJ && s1_re != MOST_NEG) |=>
         (out_re == $past(s1_im) && out_im == -$past(s1_re))); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_re) && $stable(out_im))); // R9
endmodule

// File: tb/twiddle_csd_mult_test.sv
module twiddle_csd_mult_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 13;
   localparam int FRAC = 8;
   localparam int CNUM = 181;
   localparam int MAXV = 4095;
   localparam int MINV = -4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] in_sel = 2'b00;
   logic signed [W-1:0] in_re = '0;
   logic signed [W-1:0] in_im = '0;
   logic out_valid;
   logic signed [W-1:0] out_re, out_im;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   twiddle_csd_mult uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
      .in_re(in_re), .in_im(in_im),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

   function automatic int rnd_sat(int raw);
      int q;
      q = (raw + (1 << (FRAC-1))) >>> FRAC;
      if (q > MAXV) q = MAXV;
      if (q < MINV) q = MINV;
      return q;
   endfunction

   function automatic int ref_re(int a, int b, logic [1:0] s);
      case (s)
         2'b00: return rnd_sat(a * 256);
         2'b01: return rnd_sat(CNUM * (a + b));
         2'b10: return rnd_sat(b * 256);
         default: return rnd_sat(CNUM * (b - a));
      endcase
   endfunction

   function automatic int ref_im(int a, int b, logic [1:0] s);
      case (s)
         2'b00: return rnd_sat(b * 256);
         2'b01: return rnd_sat(CNUM * (b - a));
         2'b10: return rnd_sat(-a * 256);
         default: return rnd_sat(-CNUM * (a + b));
      endcase
   endfunction

   function automatic string sel_tag(logic [1:0] s);
      case (s)
         2'b00: return "R2";
         2'b01: return "R4";
         2'b10: return "R3";
         default: return "R5";
      endcase
   endfunction

   // expectation pipeline: e1 driven one negedge ago, e2 two negedges ago
   logic e1_v = 1'b0, e2_v = 1'b0;
   int e1_re = 0, e1_im = 0, e2_re = 0, e2_im = 0;
   string e1_tag = "R1", e2_tag = "R1";
   int last_re = 0, last_im = 0;

   task automatic check_out();
      n_checks++;
      if (e2_v) begin
         if (out_valid !== 1'b1 || int'(out_re) != e2_re || int'(out_im) != e2_im) begin
            n_fail++;
            $display("FAIL %s/R1: actual v=%0b re=%0d im=%0d expected v=1 re=%0d im=%0d",
                     e2_tag, out_valid, out_re, out_im, e2_re, e2_im);
         end
         last_re = e2_re;
         last_im = e2_im;
      end else begin
         if (out_valid !== 1'b0 || int'(out_re) != last_re || int'(out_im) != last_im) begin
            n_fail++;
            $display("FAIL R9/R1: actual v=%0b re=%0d im=%0d expected v=0 re=%0d im=%0d",
                     out_valid, out_re, out_im, last_re, last_im);
         end
      end
   endtask

   task automatic step(input logic v, input int a, input int b,
                       input logic [1:0] s, input string tag);
      @(negedge clk);
      check_out();
      e2_v = e1_v; e2_re = e1_re; e2_im = e1_im; e2_tag = e1_tag;
      e1_v = v;
      e1_re = ref_re(a, b, s);
      e1_im = ref_im(a, b, s);
      e1_tag = tag;
      in_valid = v;
      in_re = W'(a);
      in_im = W'(b);
      in_sel = s;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1F2E3D4C);
      // R8: outputs are zero while in reset, even with a valid input present
      in_valid = 1'b1; in_re = 13'sd100; in_im = -13'sd7; in_sel = 2'b10;
      repeat (3) begin
         @(negedge clk);
         n_checks++;
         if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
            n_fail++;
            $display("FAIL R8: actual v=%0b re=%0d im=%0d expected v=0 re=0 im=0",
                     out_valid, out_re, out_im);
         end
      end
      in_valid = 1'b0;
      rst_n = 1'b1;

      // directed corner cases
      step(1, 1234, -567, 2'b00, "R2");
      step(1, -4096, 4095, 2'b00, "R2");
      step(1, 300, -200, 2'b10, "R3");
      step(1, -4096, 17, 2'b10, "R3");   // -(-4096) clamps to 4095
      step(1, 100, 50, 2'b01, "R4");
      step(1, 100, 50, 2'b11, "R5");
      step(1, 64, 64, 2'b01, "R6");      // tie: 90.5 -> 91
      step(1, 64, 64, 2'b11, "R6");      // tie: -90.5 -> -90
      step(0, 0, 0, 2'b00, "R9");
      step(0, 0, 0, 2'b00, "R9");
      step(1, 4095, 4095, 2'b01, "R7");
      step(1, -4096, -4096, 2'b01, "R7");
      step(1, 4095, -4096, 2'b11, "R7");
      step(1, -4096, 4095, 2'b11, "R7");
      step(1, 4095, 4095, 2'b11, "R7");
      step(1, 0, 0, 2'b01, "R4");

      // random mix with valid gaps
      for (int i = 0; i < 3000; i++) begin
         logic v;
         logic [1:0] s;
         int a, b;
         v = ($urandom_range(0, 9) < 8);
         s = 2'($urandom_range(0, 3));
         a = $urandom_range(0, 8191) - 4096;
         b = $urandom_range(0, 8191) - 4096;
         step(v, a, b, s, sel_tag(s));
      end

      // drain the pipeline
      step(0, 0, 0, 2'b00, "R9");
      step(0, 0, 0, 2'b00, "R9");
      step(0, 0, 0, 2'b00, "R9");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule